// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

This block sits between a processor core and an external bus whose devices can be 8 or 16 bits wide. The core hands it one operand transfer: a byte, a word or a long word, with a start address, a direction and, for writes, the data. The block breaks the transfer into as many external bus cycles as it needs. Each cycle is sized from the bytes still to be moved, and the port width is read from the two-bit acknowledge that the addressed device returns for that cycle.

For every bus cycle the block drives a size code, the byte address and the write lanes. It holds them steady until a valid acknowledge arrives. On reads it takes only the lanes that carry data for that cycle and builds the operand from them. When the last byte has moved, it pulses a completion flag to the core with the assembled read data. A word or long word that starts at an odd address never starts on the bus. The block reports it with an error pulse.

Top module: `dbs_top`

## Requirements
- R1: After reset, `bus_cyc`, `bus_strb`, `busy`, `done` and `err` are all low.
- R2: During each bus cycle, `bus_siz` encodes the bytes still to move: 01 for one, 10 for two, 11 for three, 00 for four.
- R3: A request accepted while idle with `req_size` other than 00 and `req_addr[0]` set raises `err` for one cycle on the next clock. It starts no bus cycle and does not raise `done`. `req_size` codes are 00 byte, 01 word, 10 long word, and 11 is handled as a long word.
- R4: `bus_ack` (active low) of 11 means no acknowledge yet. While it reads 11, size, address and write lanes hold steady. A value with bit 1 low means a 16-bit port, whatever bit 0 holds. The value 10 means an 8-bit port.
- R5: An 8-bit acknowledge moves exactly one byte, always on `bus_dout[15:8]` / `bus_din[15:8]`, and the next cycle's address is one higher. A long word to an 8-bit port steps the size code through 00, 11, 10, 01.
- R6: A 16-bit acknowledge at an even address with at least two bytes left moves two bytes. The earlier (more significant) byte uses bits 15:8, and the next address is two higher. A long word to a 16-bit port therefore takes two cycles, most significant word first.
- R7: At an odd address, a write drives the single byte on `bus_dout[7:0]` and copies it onto `bus_dout[15:8]`. A 16-bit read there takes the byte from `bus_din[7:0]`.
- R8: Lanes that carry no data for a cycle are ignored on reads. `rdata` is right-aligned: a byte in bits 7:0, a word in 15:0, a long word in 31:0, with unused upper bits zero.
- R9: Port width is decided afresh from every cycle's acknowledge. One cycle after the final acknowledge, `done` pulses for one cycle with `bus_cyc` and `busy` low, and `done` and `err` are never high together.
- R10: `bus_strb` is high for exactly the first clock of each bus cycle, and only while `bus_cyc` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_size | input | 2 | Operand size: 00 byte, 01 word, 10/11 long word |
| req_addr | input | AW | Byte address of the operand |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment pulse |
| rdata | output | 32 | Assembled read operand, valid with `done` |
| bus_cyc | output | 1 | External bus cycle active |
| bus_strb | output | 1 | First clock of a bus cycle |
| bus_rw | output | 1 | 1 for read, 0 for write |
| bus_siz | output | 2 | Size code of the current cycle |
| bus_addr | output | AW | Byte address of the current cycle |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ack | input | 2 | Active-low acknowledge and port width |

## Verification
The assertions assume three things about the inputs. The core raises `req_valid` only while `busy` is low and no response is pending. The device drives `bus_ack` to 11 whenever `bus_cyc` is low. The acknowledge code stays inside the three legal cases for each cycle. The bench's device model answers only during `bus_cyc`, with a set number of wait clocks of 11 before the width code. It then returns to 11 once the cycle ends. The core-side task waits for each response before it issues the next request.

// File: rtl/dbs_pkg.sv
// Shared constants and helpers for the dynamic bus sizing sequencer.
// Assumes a 32-bit operand and a 16-bit external data bus split into
// 8-bit lanes; lane 1 (bits 15:8) is the lane an 8-bit device uses.
package dbs_pkg;

    localparam int LANE_W  = 8;
    localparam int NLANE   = 2;
    localparam int PORT_W  = LANE_W * NLANE;
    localparam int OPND_W  = 32;
    localparam int CNT_W   = 3;

    localparam logic [1:0] OP_BYTE = 2'b00;
    localparam logic [1:0] OP_WORD = 2'b01;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } seq_state_t;

    // Size code for a given count of bytes still to move.
    function automatic logic [1:0] siz_code(input logic [CNT_W-1:0] left);
        case (left)
            3'd1:    siz_code = 2'b01;
            3'd2:    siz_code = 2'b10;
            3'd3:    siz_code = 2'b11;
            default: siz_code = 2'b00;
        endcase
    endfunction

    // Byte count of an operand from the request size field.
    function automatic logic [CNT_W-1:0] op_bytes(input logic [1:0] sz);
        case (sz)
            OP_BYTE: op_bytes = 3'd1;
            OP_WORD: op_bytes = 3'd2;
            default: op_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbs_lane_steer.sv
// Lane steering and acknowledge decode for one bus cycle.
// What it does: decodes the acknowledge into valid/width, works out
// how many bytes this cycle moves, places write bytes on the lanes and
// picks the live read lanes.
// Assumes: opnd_hi holds the next operand byte in bits 15:8 and the one
// after it in bits 7:0; purely combinational.
module dbs_lane_steer
    import dbs_pkg::*;
(
    input  logic [PORT_W-1:0]  opnd_hi,
    input  logic               addr0,
    input  logic [CNT_W-1:0]   left,
    input  logic [1:0]         ack_n,
    input  logic [PORT_W-1:0]  din,
    output logic [PORT_W-1:0]  dout,
    output logic               ack_ok,
    output logic               wide,
    output logic [1:0]         moved,
    output logic [PORT_W-1:0]  rbytes
);

    localparam int TOP = NLANE - 1;

    logic [LANE_W-1:0] first_b;
    logic [LANE_W-1:0] second_b;
    logic              two;

    assign first_b  = opnd_hi[PORT_W-1 -: LANE_W];
    assign second_b = opnd_hi[LANE_W-1:0];

    // Write lane placement: the upper lane always carries the next byte,
    // the lower lane carries the following byte, or a copy at odd addresses.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        if (g == TOP) begin : g_up
            assign dout[g*LANE_W +: LANE_W] = first_b;
        end else begin : g_lo
            assign dout[g*LANE_W +: LANE_W] = addr0 ? first_b : second_b;
        end
    end

    // Acknowledge decode: bit 1 low marks a wide port, 10 a narrow one.
    always_comb begin
        wide   = ~ack_n[1];
        ack_ok = ~ack_n[1] | (ack_n == 2'b10);
    end

    // Byte count of this cycle: two only for an even wide transfer.
    always_comb begin
        two   = wide && !addr0 && (left >= 3'd2);
        moved = two ? 2'd2 : 2'd1;
    end

    // Read lane selection: unused lanes are dropped, result right-aligned.
    always_comb begin
        if (two) begin
            rbytes = din;
        end else if (wide && addr0) begin
            rbytes = {{LANE_W{1'b0}}, din[LANE_W-1:0]};
        end else begin
            rbytes = {{LANE_W{1'b0}}, din[PORT_W-1 -: LANE_W]};
        end
    end

endmodule

// File: rtl/dbs_ctrl.sv
// Transfer sequencer for the dynamic bus sizing block.
// What it does: accepts one request while idle, rejects misaligned
// word/long requests, runs bus cycles until no bytes remain, shifts write
// bytes out and read bytes in, then pulses done.
// Assumes: the lane steering block supplies ack_ok/moved/rbytes for the
// current cycle; requests arriving while busy are ignored.
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_size,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_write,
    input  logic [OPND_W-1:0]  req_wdata,
    input  logic               ack_ok,
    input  logic [1:0]         moved,
    input  logic [PORT_W-1:0]  rbytes,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [OPND_W-1:0]  rdata,
    output logic               bus_cyc,
    output logic               bus_strb,
    output logic               bus_rw,
    output logic [1:0]         bus_siz,
    output logic [AW-1:0]      bus_addr,
    output logic [PORT_W-1:0]  opnd_hi,
    output logic [CNT_W-1:0]   left
);

    localparam int SHW = OPND_W - PORT_W;

    seq_state_t         state;
    logic [CNT_W-1:0]   left_q;
    logic [AW-1:0]      addr_q;
    logic [OPND_W-1:0]  wsh_q;
    logic [OPND_W-1:0]  rbuf_q;
    logic               rd_q;
    logic               misalign;
    logic               last;
    logic [OPND_W-1:0]  rbuf_nx;
    logic [OPND_W-1:0]  wsh_nx;
    logic [OPND_W-1:0]  wdata_al;

    // Request checks: only bytes may start at an odd address.
    always_comb begin
        misalign = (req_size != OP_BYTE) && req_addr[0];
    end

    // Left-align the write operand so the next byte sits at the top.
    always_comb begin
        case (req_size)
            OP_BYTE: wdata_al = {req_wdata[7:0], 24'h0};
            OP_WORD: wdata_al = {req_wdata[15:0], 16'h0};
            default: wdata_al = req_wdata;
        endcase
    end

    // Next shift-register values after this cycle's bytes have moved.
    always_comb begin
        last = (left_q == {1'b0, moved});
        if (moved == 2'd2) begin
            rbuf_nx = {rbuf_q[SHW-1:0], rbytes};
            wsh_nx  = {wsh_q[SHW-1:0], {PORT_W{1'b0}}};
        end else begin
            rbuf_nx = {rbuf_q[OPND_W-LANE_W-1:0], rbytes[LANE_W-1:0]};
            wsh_nx  = {wsh_q[OPND_W-LANE_W-1:0], {LANE_W{1'b0}}};
        end
    end

    // Sequencer state, counters and operand shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            left_q   <= '0;
            addr_q   <= '0;
            wsh_q    <= '0;
            rbuf_q   <= '0;
            rd_q     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rdata    <= '0;
            bus_strb <= 1'b0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            bus_strb <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (misalign) begin
                            err <= 1'b1;
                        end else begin
                            state    <= ST_BUS;
                            left_q   <= op_bytes(req_size);
                            addr_q   <= req_addr;
                            wsh_q    <= wdata_al;
                            rbuf_q   <= '0;
                            rd_q     <= !req_write;
                            bus_strb <= 1'b1;
                        end
                    end
                end
                ST_BUS: begin
                    if (ack_ok) begin
                        left_q <= left_q - {1'b0, moved};
                        addr_q <= addr_q + AW'(moved);
                        wsh_q  <= wsh_nx;
                        rbuf_q <= rbuf_nx;
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                            rdata <= rd_q ? rbuf_nx : '0;
                        end else begin
                            bus_strb <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus-side view of the current cycle.
    always_comb begin
        busy     = (state == ST_BUS);
        bus_cyc  = busy;
        bus_rw   = rd_q;
        bus_siz  = siz_code(left_q);
        bus_addr = addr_q;
        opnd_hi  = wsh_q[OPND_W-1 -: PORT_W];
        left     = left_q;
    end

endmodule

// File: rtl/dbs_top.sv
// Top level of the dynamic bus sizing cycle sequencer.
// What it does: joins the sequencer to the lane steering logic and
// exposes the core-side request interface and the external bus.
// Assumes: a 16-bit external bus with 8-bit devices on bits 15:8;
// acknowledge is active low and is 11 outside bus cycles.
module dbs_top
    import dbs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_size,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_write,
    input  logic [31:0]        req_wdata,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [31:0]        rdata,
    output logic               bus_cyc,
    output logic               bus_strb,
    output logic               bus_rw,
    output logic [1:0]         bus_siz,
    output logic [AW-1:0]      bus_addr,
    output logic [15:0]        bus_dout,
    input  logic [15:0]        bus_din,
    input  logic [1:0]         bus_ack
);

    logic              ack_ok;
    logic              wide;
    logic [1:0]        moved;
    logic [PORT_W-1:0] rbytes;
    logic [PORT_W-1:0] opnd_hi;
    logic [CNT_W-1:0]  left;
    logic              unused_wide;

    assign unused_wide = wide;

    dbs_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .ack_ok    (ack_ok),
        .moved     (moved),
        .rbytes    (rbytes),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .bus_cyc   (bus_cyc),
        .bus_strb  (bus_strb),
        .bus_rw    (bus_rw),
        .bus_siz   (bus_siz),
        .bus_addr  (bus_addr),
        .opnd_hi   (opnd_hi),
        .left      (left)
    );

    dbs_lane_steer u_steer (
        .opnd_hi (opnd_hi),
        .addr0   (bus_addr[0]),
        .left    (left),
        .ack_n   (bus_ack),
        .din     (bus_din),
        .dout    (bus_dout),
        .ack_ok  (ack_ok),
        .wide    (wide),
        .moved   (moved),
        .rbytes  (rbytes)
    );

endmodule

// File: rtl/dbs_chk.sv
// Property checker for dbs_top, attached with bind below.
// Assumes the core only requests while idle and the device keeps the
// acknowledge at 11 outside bus cycles.
module dbs_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_size,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          bus_cyc,
    input logic          bus_strb,
    input logic [1:0]    bus_siz,
    input logic [AW-1:0] bus_addr,
    input logic [15:0]   bus_dout,
    input logic [1:0]    bus_ack
);

    // R3
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_size != 2'b00 && req_addr[0]) |=> (err && !bus_cyc));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack == 2'b11) |=>
        (bus_cyc && $stable(bus_siz) && $stable(bus_addr) && $stable(bus_dout)));

    // R5
    narrow_long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack == 2'b10 && bus_siz == 2'b00) |=>
        (bus_cyc && bus_siz == 2'b11 && bus_addr == AW'($past(bus_addr) + 1'b1)));

    // R6
    wide_long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack[1] && bus_siz == 2'b00 && !bus_addr[0]) |=>
        (bus_cyc && bus_siz == 2'b10 && bus_addr == AW'($past(bus_addr) + 2'd2)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_cyc && !busy));

    // R9
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    // R10
    strb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strb |-> bus_cyc);

    // R10
    strb_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> bus_strb);

endmodule

bind dbs_top dbs_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_cyc   (bus_cyc),
    .bus_strb  (bus_strb),
    .bus_siz   (bus_siz),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_ack   (bus_ack)
);

// File: tb/tb_dbs_top.sv
// Scoreboard bench for dbs_top: a driver task queues the expected response,
// a monitor pops it on done/err, a device model checks every bus cycle.
module tb_dbs_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          busy, done, err;
    logic [31:0]   rdata;
    logic          bus_cyc, bus_strb, bus_rw;
    logic [1:0]    bus_siz;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic [1:0]    bus_ack = 2'b11;

    dbs_top #(.AW(AW)) dut (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        bit          is_err;
        bit          chk_data;
        logic [31:0] data;
    } resp_t;

    resp_t       sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          resp_cnt = 0;

    logic [7:0]  mem [64];
    logic [7:0]  ob [4];
    int          rem_e = 0;
    logic [AW-1:0] adr_e = '0;
    int          k_e = 0;
    bit          wr_e = 0;
    int          mode = 1;
    bit          tog = 0;
    bit          ack_alt = 0;
    int          waits = 0;
    int          wcnt = 0;
    bit          first = 1;
    int          ncyc = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input int n);
        case (n)
            1: code_of = 2'b01;
            2: code_of = 2'b10;
            3: code_of = 2'b11;
            default: code_of = 2'b00;
        endcase
    endfunction

    // Device model: wait states, width per mode, per-cycle lane checks.
    always @(negedge clk) begin
        if (!rst_n || !bus_cyc) begin
            bus_ack <= 2'b11;
            wcnt = 0;
            first = 1;
        end else begin
            check(bus_strb == first, "R10", 32'(bus_strb), 32'(first));
            first = 0;
            if (wcnt < waits) begin
                wcnt++;
                bus_ack <= 2'b11;
            end else begin
                automatic bit w16 = (mode == 1) || (mode == 2 && tog);
                automatic int mv = (w16 && !adr_e[0] && rem_e >= 2) ? 2 : 1;
                automatic logic [5:0] a = adr_e[5:0];
                automatic logic [7:0] b = ob[k_e];
                check(bus_siz == code_of(rem_e), "R2", 32'(bus_siz), 32'(code_of(rem_e)));
                check(bus_addr == adr_e, "R5", 32'(bus_addr), 32'(adr_e));
                check(bus_rw == !wr_e, "R8", 32'(bus_rw), 32'(!wr_e));
                if (wr_e) begin
                    if (adr_e[0]) begin
                        check(bus_dout == {b, b}, "R7", 32'(bus_dout), 32'({b, b}));
                    end else if (mv == 2) begin
                        check(bus_dout == {b, ob[k_e+1]}, "R6", 32'(bus_dout), 32'({b, ob[k_e+1]}));
                    end else begin
                        check(bus_dout[15:8] == b, "R5", 32'(bus_dout[15:8]), 32'(b));
                    end
                    mem[a] = b;
                    if (mv == 2) mem[a+6'd1] = ob[k_e+1];
                end else if (w16) begin
                    bus_din <= {mem[{a[5:1], 1'b0}], mem[{a[5:1], 1'b1}]};
                end else begin
                    bus_din <= {mem[a], 8'hEE};
                end
                if (w16) begin
                    bus_ack <= ack_alt ? 2'b01 : 2'b00;
                    ack_alt = !ack_alt;
                end else begin
                    bus_ack <= 2'b10;
                end
                rem_e -= mv;
                adr_e += AW'(mv);
                k_e += mv;
                ncyc++;
                if (mode == 2) tog = !tog;
                wcnt = 0;
                first = 1;
            end
        end
    end

    // Monitor: pop the expected response when done or err appears.
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            if (sb_q.size() == 0) begin
                check(0, "R9", 32'({done, err}), 32'h0);
            end else begin
                automatic resp_t e = sb_q.pop_front();
                check(err == e.is_err, e.is_err ? "R3" : "R9", 32'(err), 32'(e.is_err));
                check(done == !e.is_err, e.is_err ? "R3" : "R9", 32'(done), 32'(!e.is_err));
                if (e.chk_data) check(rdata == e.data, "R8", rdata, e.data);
            end
            resp_cnt++;
        end
    end

    // Driver: queue the expected response, issue the request, wait for it.
    task automatic xfer(input logic [1:0] sz, input logic [AW-1:0] ad, input bit wr, input logic [31:0] wd);
        automatic int n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        automatic bit mis = (sz != 2'b00) && ad[0];
        automatic resp_t e;
        automatic int c0 = ncyc;
        automatic int r0 = resp_cnt;
        automatic logic [31:0] exp = '0;
        for (int i = 0; i < n; i++) exp = {exp[23:0], mem[6'(ad[5:0] + 6'(i))]};
        for (int i = 0; i < 4; i++) ob[i] = (i < n) ? wd[(n-1-i)*8 +: 8] : 8'h00;
        e.is_err = mis;
        e.chk_data = !mis && !wr;
        e.data = exp;
        sb_q.push_back(e);
        if (!mis) begin
            rem_e = n; adr_e = ad; k_e = 0; wr_e = wr;
        end
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = ad; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        wait (resp_cnt > r0);
        @(negedge clk);
        if (mis) begin
            check(ncyc == c0, "R3", 32'(ncyc - c0), 32'h0);
        end else begin
            check(rem_e == 0, "R9", 32'(rem_e), 32'h0);
            if (wr) begin
                for (int i = 0; i < n; i++)
                    check(mem[6'(ad[5:0] + 6'(i))] == ob[i], "R6",
                          32'(mem[6'(ad[5:0] + 6'(i))]), 32'(ob[i]));
            end
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R9", 32'h0, 32'h1);
        report();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!bus_cyc && !busy && !done && !err && !bus_strb, "R1",
              32'({bus_cyc, busy, done, err, bus_strb}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_cyc && !busy && !done && !err, "R1",
              32'({bus_cyc, busy, done, err}), 32'h0);

        // 16-bit port: R6 long, R7 odd byte, R8 reads
        mode = 1; waits = 0;
        xfer(2'b10, 24'd4, 1, 32'h11223344);
        xfer(2'b10, 24'd4, 0, 32'h0);
        xfer(2'b01, 24'd10, 1, 32'h0000A55A);
        xfer(2'b01, 24'd10, 0, 32'h0);
        xfer(2'b00, 24'd7, 1, 32'h000000C3);
        xfer(2'b00, 24'd7, 0, 32'h0);
        xfer(2'b00, 24'd6, 0, 32'h0);
        waits = 2;
        xfer(2'b11, 24'd12, 1, 32'hDEADBEEF);
        xfer(2'b10, 24'd12, 0, 32'h0);

        // 8-bit port: R5 size stepping 00,11,10,01
        mode = 0; waits = 0;
        xfer(2'b10, 24'd20, 1, 32'h01020304);
        xfer(2'b10, 24'd20, 0, 32'h0);
        xfer(2'b01, 24'd4, 0, 32'h0);
        xfer(2'b00, 24'd21, 0, 32'h0);
        waits = 1;
        xfer(2'b00, 24'd25, 1, 32'h0000005A);

        // Mixed widths per cycle: R9 re-sampled width
        mode = 2; waits = 0; tog = 1;
        xfer(2'b10, 24'd4, 0, 32'h0);
        tog = 0;
        xfer(2'b10, 24'd32, 1, 32'hCAFEF00D);
        xfer(2'b10, 24'd32, 0, 32'h0);

        // R3: misaligned word and long rejected, byte at odd accepted
        mode = 1;
        xfer(2'b01, 24'd3, 1, 32'h00001234);
        xfer(2'b10, 24'd5, 0, 32'h0);
        xfer(2'b11, 24'd9, 1, 32'h12345678);
        xfer(2'b00, 24'd5, 0, 32'h0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R9", 32'(sb_q.size()), 32'h0);
        report();
    end

endmodule